// File: doc/BRIEF.md
# Program Counter and Branch Unit

This unit owns the program counter of a small 8-bit processor with 16-bit instructions and 12-bit byte addresses. Each issued instruction arrives already decoded as an operation class, together with its address field, its immediate byte, the two register operands it names, the value of register zero and a key-match flag. From these the unit decides the next PC. It covers sequential advance, absolute and indexed jumps, register and key skips, and subroutine call and return. The return stack lives in ordinary memory.

Calls and returns use a single memory port that carries one request at a time. The unit holds the request until the memory acknowledges it. Until then it reports busy and refuses new instructions. A jump whose target is the jump itself is treated as a halt: the unit sets a sticky pause flag and freezes the PC until a resume pulse arrives.

All PC and stack arithmetic wraps modulo 4096. The stack pointer steps by two bytes: it moves down on a call and up on a return.

Top module: `pc_branch_unit`

## Requirements
- R1: While rst_n is low, and after its release, pc is 0x200, sp is 0xFFE, and paused, busy and mem_req are all 0.
- R2: An instruction is issued when op_valid is high, busy is low and paused is low. Class 0 (sequential), and any class code above 10, set pc to pc+2 one clock edge after issue.
- R3: Class 1 (jump) sets pc to op_addr one edge after issue. If op_addr equals the current pc, so that op_addr+2 equals pc+2, paused also becomes 1 at that edge.
- R4: While paused is 1, issued operations are ignored and pc holds its value. A one-cycle resume pulse clears paused at the next edge, and instructions are accepted again after that.
- R5: Class 4 skips when reg_x equals op_imm, and class 5 skips when they differ. A skip sets pc to pc+4. Otherwise pc becomes pc+2.
- R6: Class 6 skips when reg_x equals reg_y, and class 7 skips when they differ. Taken and not-taken steps are the same as in R5.
- R7: Class 9 skips when key_match is 1, and class 10 skips when key_match is 0. Taken and not-taken steps are the same as in R5.
- R8: Class 8 (indexed jump) sets pc to op_addr + reg_v0, modulo 4096, one edge after issue.
- R9: Class 2 (call) raises mem_req and mem_we, with mem_addr equal to sp and mem_wdata equal to pc+2 zero-extended to 16 bits. These signals hold steady until mem_ack. At the edge where mem_ack is sampled, sp becomes sp-2 (wrapping) and pc becomes op_addr.
- R10: Class 3 (return) raises mem_req with mem_we low and mem_addr equal to sp+2 (wrapping), held until mem_ack. At the acknowledging edge, pc becomes mem_rdata[11:0] and sp becomes sp+2.
- R11: busy is 1 from the edge after a call or return is issued until the acknowledging edge. op_valid is ignored while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Decoded instruction present this cycle |
| op_class | input | 4 | Operation class code (see requirements) |
| op_addr | input | 12 | Address field of the instruction |
| op_imm | input | 8 | Immediate byte of the instruction |
| reg_x | input | 8 | Value of the first named register |
| reg_y | input | 8 | Value of the second named register |
| reg_v0 | input | 8 | Value of register zero |
| key_match | input | 1 | Pressed key equals the register value |
| resume | input | 1 | Clears the pause flag |
| pc | output | 12 | Program counter |
| sp | output | 12 | Stack pointer |
| paused | output | 1 | Sticky halt flag |
| busy | output | 1 | Stack access in progress |
| mem_req | output | 1 | Stack memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 12 | Stack memory address |
| mem_wdata | output | 16 | Return address being pushed |
| mem_rdata | input | 16 | Data returned by a read |
| mem_ack | input | 1 | Memory completes the request |

## Verification
All non-stack classes update pc at the first edge after issue. The bench therefore drives op_valid for one cycle from a falling edge and reads pc at the next falling edge. Calls and returns take two edges when memory answers one cycle after the request. The bench samples the request fields half a cycle after the issuing edge. It then waits at falling edges until busy drops and checks pc and sp there. Pause and busy are checked by issuing an instruction during the blocked cycle and confirming at the following falling edge that pc has not moved.

// File: rtl/pcbu_pkg.sv
package pcbu_pkg;
  localparam int unsigned PCBU_AW = 12;
  localparam int unsigned PCBU_DW = 8;

  typedef enum logic [3:0] {
    OPC_SEQ    = 4'd0,
    OPC_JMP    = 4'd1,
    OPC_CALL   = 4'd2,
    OPC_RET    = 4'd3,
    OPC_SKEQ_I = 4'd4,
    OPC_SKNE_I = 4'd5,
    OPC_SKEQ_R = 4'd6,
    OPC_SKNE_R = 4'd7,
    OPC_JIDX   = 4'd8,
    OPC_SKKEY  = 4'd9,
    OPC_SKNKEY = 4'd10
  } opc_e;

  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_state_e;

  function automatic logic [PCBU_AW-1:0] addr_add(input logic [PCBU_AW-1:0] a,
                                                  input logic [PCBU_AW-1:0] b);
    return a + b;
  endfunction

  function automatic logic [PCBU_AW-1:0] addr_sub(input logic [PCBU_AW-1:0] a,
                                                  input logic [PCBU_AW-1:0] b);
    return a - b;
  endfunction

  function automatic logic skip_taken(input opc_e cls,
                                      input logic [PCBU_DW-1:0] vx,
                                      input logic [PCBU_DW-1:0] vy,
                                      input logic [PCBU_DW-1:0] imm,
                                      input logic key);
    logic t;
    case (cls)
      OPC_SKEQ_I: t = (vx == imm);
      OPC_SKNE_I: t = (vx != imm);
      OPC_SKEQ_R: t = (vx == vy);
      OPC_SKNE_R: t = (vx != vy);
      OPC_SKKEY:  t = key;
      OPC_SKNKEY: t = !key;
      default:    t = 1'b0;
    endcase
    return t;
  endfunction

  function automatic logic is_skip(input opc_e cls);
    return (cls == OPC_SKEQ_I) || (cls == OPC_SKNE_I) || (cls == OPC_SKEQ_R) ||
           (cls == OPC_SKNE_R) || (cls == OPC_SKKEY) || (cls == OPC_SKNKEY);
  endfunction
endpackage

// File: rtl/pcbu_next.sv
module pcbu_next
  import pcbu_pkg::*;
#(
  parameter int unsigned AW   = PCBU_AW,
  parameter int unsigned DW   = PCBU_DW,
  parameter int unsigned STEP = 2
) (
  input  opc_e          cls,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] imm,
  input  logic [DW-1:0] vx,
  input  logic [DW-1:0] vy,
  input  logic [DW-1:0] v0,
  input  logic          key,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] seq_pc,
  output logic          halt_hit,
  output logic          want_push,
  output logic          want_pop
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  logic [AW-1:0] skip_pc;
  logic [AW-1:0] idx_pc;
  logic          take_skip;

  assign seq_pc    = addr_add(cur_pc, STEP_A);
  assign skip_pc   = addr_add(seq_pc, STEP_A);
  assign idx_pc    = addr_add(addr, {{(AW-DW){1'b0}}, v0});
  assign take_skip = skip_taken(cls, vx, vy, imm, key);

  always_comb begin
    next_pc = seq_pc;
    if (cls == OPC_JMP)       next_pc = addr;
    else if (cls == OPC_JIDX) next_pc = idx_pc;
    else if (is_skip(cls))    next_pc = take_skip ? skip_pc : seq_pc;
  end

  assign halt_hit  = (cls == OPC_JMP) && (addr_add(addr, STEP_A) == seq_pc);
  assign want_push = (cls == OPC_CALL);
  assign want_pop  = (cls == OPC_RET);
endmodule

// File: rtl/pcbu_stack.sv
module pcbu_stack
  import pcbu_pkg::*;
#(
  parameter int unsigned AW      = PCBU_AW,
  parameter int unsigned MW      = 16,
  parameter int unsigned STEP    = 2,
  parameter logic [AW-1:0] SP_INIT = 12'hFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_push,
  input  logic          start_pop,
  input  logic [AW-1:0] push_val,
  input  logic [AW-1:0] push_target,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [MW-1:0] mem_wdata,
  input  logic [MW-1:0] mem_rdata,
  input  logic          mem_ack,
  output logic          busy,
  output logic          load_pc,
  output logic [AW-1:0] load_val,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] STEP_A = AW'(STEP);

  stk_state_e    state;
  logic [AW-1:0] req_addr;
  logic [MW-1:0] wdata_q;
  logic [AW-1:0] target_q;
  logic          unused_rdata_hi;

  assign unused_rdata_hi = ^mem_rdata[MW-1:AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= STK_IDLE;
      sp       <= SP_INIT;
      req_addr <= '0;
      wdata_q  <= '0;
      target_q <= '0;
    end else begin
      case (state)
        STK_IDLE: begin
          if (start_push) begin
            state    <= STK_PUSH;
            req_addr <= sp;
            wdata_q  <= {{(MW-AW){1'b0}}, push_val};
            target_q <= push_target;
          end else if (start_pop) begin
            state    <= STK_POP;
            req_addr <= addr_add(sp, STEP_A);
          end
        end
        STK_PUSH: begin
          if (mem_ack) begin
            sp    <= addr_sub(sp, STEP_A);
            state <= STK_IDLE;
          end
        end
        STK_POP: begin
          if (mem_ack) begin
            sp    <= addr_add(sp, STEP_A);
            state <= STK_IDLE;
          end
        end
        default: state <= STK_IDLE;
      endcase
    end
  end

  assign mem_req   = (state != STK_IDLE);
  assign mem_we    = (state == STK_PUSH);
  assign mem_addr  = req_addr;
  assign mem_wdata = wdata_q;
  assign busy      = (state != STK_IDLE);
  assign load_pc   = mem_ack && (state != STK_IDLE);
  assign load_val  = (state == STK_PUSH) ? target_q : mem_rdata[AW-1:0];

  AST_REQ_HELD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))) // R9
    else $error("request dropped or changed before ack");

  AST_SP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sp == $past(sp)) || (sp == addr_add($past(sp), STEP_A)) ||
              (sp == addr_sub($past(sp), STEP_A)))) // R10
    else $error("stack pointer moved by other than one step");
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcbu_pkg::*;
#(
  parameter int unsigned AW       = PCBU_AW,
  parameter int unsigned DW       = PCBU_DW,
  parameter int unsigned MW       = 16,
  parameter int unsigned CW       = 4,
  parameter logic [AW-1:0] RESET_PC = 12'h200,
  parameter logic [AW-1:0] SP_INIT  = 12'hFFE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [CW-1:0] op_class,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_imm,
  input  logic [DW-1:0] reg_x,
  input  logic [DW-1:0] reg_y,
  input  logic [DW-1:0] reg_v0,
  input  logic          key_match,
  input  logic          resume,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] sp,
  output logic          paused,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [MW-1:0] mem_wdata,
  input  logic [MW-1:0] mem_rdata,
  input  logic          mem_ack
);
  localparam int unsigned STEP = 2;

  opc_e          cls;
  logic          issue;
  logic [AW-1:0] next_pc;
  logic [AW-1:0] seq_pc;
  logic          halt_hit;
  logic          want_push;
  logic          want_pop;
  logic          start_push;
  logic          start_pop;
  logic          stk_load;
  logic [AW-1:0] stk_val;

  assign cls   = opc_e'(op_class);
  assign issue = op_valid && !busy && !paused;

  pcbu_next #(.AW(AW), .DW(DW), .STEP(STEP)) u_next (
    .cls      (cls),
    .cur_pc   (pc),
    .addr     (op_addr),
    .imm      (op_imm),
    .vx       (reg_x),
    .vy       (reg_y),
    .v0       (reg_v0),
    .key      (key_match),
    .next_pc  (next_pc),
    .seq_pc   (seq_pc),
    .halt_hit (halt_hit),
    .want_push(want_push),
    .want_pop (want_pop)
  );

  assign start_push = issue && want_push;
  assign start_pop  = issue && want_pop;

  pcbu_stack #(.AW(AW), .MW(MW), .STEP(STEP), .SP_INIT(SP_INIT)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_push (start_push),
    .start_pop  (start_pop),
    .push_val   (seq_pc),
    .push_target(op_addr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .mem_ack    (mem_ack),
    .busy       (busy),
    .load_pc    (stk_load),
    .load_val   (stk_val),
    .sp         (sp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= RESET_PC;
    end else if (stk_load) begin
      pc <= stk_val;
    end else if (issue && !want_push && !want_pop) begin
      pc <= next_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      paused <= 1'b0;
    else if (paused) paused <= !resume;
    else             paused <= issue && halt_hit;
  end

  AST_PAUSE_FREEZES_PC: assert property (@(posedge clk) disable iff (!rst_n)
    paused |=> (pc == $past(pc))) // R4
    else $error("pc moved while paused");

  AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !resume) |=> paused) // R4
    else $error("pause cleared without resume");

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && !paused && op_class == CW'(OPC_JMP)) |=> (pc == $past(op_addr))) // R3
    else $error("jump target not loaded");

  AST_SKIP_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && is_skip(cls)) |=>
      ((pc == addr_add($past(pc), AW'(2))) || (pc == addr_add($past(pc), AW'(4))))) // R5
    else $error("skip moved pc by an illegal amount");

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> $stable(pc)) // R11
    else $error("pc moved while stack access pending");
endmodule

// File: tb/sim_pc_branch_unit.sv
module sim_pc_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_class = 4'd0;
  logic [11:0] op_addr = '0;
  logic [7:0]  op_imm = '0;
  logic [7:0]  reg_x = '0;
  logic [7:0]  reg_y = '0;
  logic [7:0]  reg_v0 = '0;
  logic        key_match = 1'b0;
  logic        resume = 1'b0;
  logic [11:0] pc;
  logic [11:0] sp;
  logic        paused;
  logic        busy;
  logic        mem_req;
  logic        mem_we;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  logic [15:0] bmem [0:63];
  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pc_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_addr(op_addr), .op_imm(op_imm), .reg_x(reg_x), .reg_y(reg_y),
    .reg_v0(reg_v0), .key_match(key_match), .resume(resume), .pc(pc), .sp(sp),
    .paused(paused), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // stack memory model: answers one cycle after a request appears
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) bmem[mem_addr[6:1]] <= mem_wdata;
      else        mem_rdata <= bmem[mem_addr[6:1]];
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  // one-cycle issue from a falling edge; returns at the falling edge after completion
  task automatic issue(input logic [3:0] c, input logic [11:0] a, input logic [7:0] im,
                       input logic [7:0] x, input logic [7:0] y, input logic [7:0] v0,
                       input logic k);
    op_class = c; op_addr = a; op_imm = im; reg_x = x; reg_y = y; reg_v0 = v0;
    key_match = k; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic goto(input logic [11:0] a);
    issue(4'd1, a, 8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1", "pc", pc, 12'h200);
    chk("R1", "sp", sp, 12'hFFE);
    chk("R1", "paused", paused, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "mem_req", mem_req, 0);
  endtask

  task automatic t_ret_wrap;
    bmem[0] = 16'h0345;
    op_class = 4'd3; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk("R10", "pop req", mem_req, 1);
    chk("R10", "pop we", mem_we, 0);
    chk("R10", "pop addr wraps", mem_addr, 12'h000);
    chk("R11", "busy during pop", busy, 1);
    while (busy) @(negedge clk);
    chk("R10", "pc from stack", pc, 12'h345);
    chk("R10", "sp after pop", sp, 12'h000);
  endtask

  task automatic t_seq;
    goto(12'h240);
    issue(4'd0, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R2", "seq", pc, 12'h242);
    issue(4'd15, 12'h7AB, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R2", "unknown class", pc, 12'h244);
    goto(12'hFFE);
    issue(4'd0, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R2", "seq wrap", pc, 12'h000);
  endtask

  task automatic t_jump;
    goto(12'h300);
    chk("R3", "jump", pc, 12'h300);
    goto(12'h302);
    chk("R3", "jump next no halt", paused, 0);
  endtask

  task automatic t_skip_imm;
    goto(12'h100);
    issue(4'd4, 12'h0, 8'h5A, 8'h5A, 8'h0, 8'h0, 1'b0);
    chk("R5", "eq imm taken", pc, 12'h104);
    issue(4'd4, 12'h0, 8'h5A, 8'h5B, 8'h0, 8'h0, 1'b0);
    chk("R5", "eq imm not taken", pc, 12'h106);
    issue(4'd5, 12'h0, 8'h10, 8'h11, 8'h0, 8'h0, 1'b0);
    chk("R5", "ne imm taken", pc, 12'h10A);
    issue(4'd5, 12'h0, 8'h10, 8'h10, 8'h0, 8'h0, 1'b0);
    chk("R5", "ne imm not taken", pc, 12'h10C);
  endtask

  task automatic t_skip_reg;
    goto(12'h120);
    issue(4'd6, 12'h0, 8'h0, 8'h33, 8'h33, 8'h0, 1'b0);
    chk("R6", "eq reg taken", pc, 12'h124);
    issue(4'd6, 12'h0, 8'h0, 8'h33, 8'h34, 8'h0, 1'b0);
    chk("R6", "eq reg not taken", pc, 12'h126);
    issue(4'd7, 12'h0, 8'h0, 8'h01, 8'h80, 8'h0, 1'b0);
    chk("R6", "ne reg taken", pc, 12'h12A);
    issue(4'd7, 12'h0, 8'h0, 8'hFF, 8'hFF, 8'h0, 1'b0);
    chk("R6", "ne reg not taken", pc, 12'h12C);
  endtask

  task automatic t_key;
    goto(12'h140);
    issue(4'd9, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1);
    chk("R7", "key skip taken", pc, 12'h144);
    issue(4'd9, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R7", "key skip not taken", pc, 12'h146);
    issue(4'd10, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R7", "nokey skip taken", pc, 12'h14A);
    issue(4'd10, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1);
    chk("R7", "nokey skip not taken", pc, 12'h14C);
  endtask

  task automatic t_jidx;
    issue(4'd8, 12'h100, 8'h0, 8'h0, 8'h0, 8'hFF, 1'b0);
    chk("R8", "indexed", pc, 12'h1FF);
    issue(4'd8, 12'hFF0, 8'h0, 8'h0, 8'h0, 8'h20, 1'b0);
    chk("R8", "indexed wrap", pc, 12'h010);
  endtask

  task automatic t_calls;
    goto(12'h400);
    op_class = 4'd2; op_addr = 12'h600; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    chk("R9", "push req", mem_req, 1);
    chk("R9", "push we", mem_we, 1);
    chk("R9", "push addr", mem_addr, 12'h000);
    chk("R9", "push data", mem_wdata, 16'h0402);
    while (busy) @(negedge clk);
    chk("R9", "call pc", pc, 12'h600);
    chk("R9", "call sp wraps", sp, 12'hFFE);
    issue(4'd2, 12'h700, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R9", "nested call pc", pc, 12'h700);
    chk("R9", "nested sp", sp, 12'hFFC);
    chk("R9", "nested pushed word", bmem[6'h3F], 16'h0602);
    issue(4'd3, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R10", "ret inner pc", pc, 12'h602);
    chk("R10", "ret inner sp", sp, 12'hFFE);
    issue(4'd3, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R10", "ret outer pc", pc, 12'h402);
    chk("R10", "ret outer sp", sp, 12'h000);
  endtask

  task automatic t_busy;
    goto(12'h480);
    op_class = 4'd2; op_addr = 12'h6A0; op_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    op_class = 4'd1; op_addr = 12'h123;   // offered while busy
    @(posedge clk); @(negedge clk);
    op_valid = 1'b0;
    while (busy) @(negedge clk);
    chk("R11", "op during busy ignored", pc, 12'h6A0);
    @(negedge clk);
    chk("R11", "pc stays after busy", pc, 12'h6A0);
    issue(4'd3, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R11", "return after busy test", pc, 12'h482);
  endtask

  task automatic t_halt;
    goto(12'h500);
    goto(12'h500);
    chk("R3", "self jump pc", pc, 12'h500);
    chk("R3", "self jump pauses", paused, 1);
    issue(4'd0, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R4", "seq ignored while paused", pc, 12'h500);
    issue(4'd1, 12'h555, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R4", "jump ignored while paused", pc, 12'h500);
    chk("R4", "still paused", paused, 1);
    resume = 1'b1;
    @(posedge clk); @(negedge clk);
    resume = 1'b0;
    chk("R4", "resume clears", paused, 0);
    chk("R4", "pc after resume", pc, 12'h500);
    issue(4'd0, 12'h0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0);
    chk("R4", "runs after resume", pc, 12'h502);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 64; i++) bmem[i] = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ret_wrap();
    t_seq();
    t_jump();
    t_skip_imm();
    t_skip_reg();
    t_key();
    t_jidx();
    t_calls();
    t_busy();
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule